// File: doc/BRIEF.md
# Link Test Pattern Checker

This block sits behind the symbol decoder on the receive side of a camera serial link. Each clock it may take one 32-bit word of four byte lanes, with a 4-bit flag that marks which lanes hold control characters. It drops idle words wherever they appear. It frames packets on start and end control characters that are sent four times across the lanes, and a majority vote lets a character survive one corrupted copy.

After a start character, the first word gives the packet type. A connection-test packet carries a byte counter that is staggered across the lanes. The counter starts at 0 and steps by 4 per word up to the word whose low byte is 0xFC. The block compares every counter word against the expected bytes. It counts good packets, bad packets and mismatching words in three saturating counters, which a synchronous clear input resets. Packets of any other type are passed over up to their end character, so framing stays intact.

Top module: `lane_test_checker`

## Requirements
- R1: An idle word is discarded wherever it appears, including inside a packet. An idle word is data 0xB53C3CBC (lane 0 is bits 7:0) with flags 4'b0111.
- R2: A start character (K27.7 = 0xFB, all four flags set) is recognised even if one lane's copy has a corrupted bit.
- R3: A type word of 0x04 in every lane with flags clear opens a test packet. Any other type word is skipped up to the end character (K29.7 = 0xFD) and changes no counter.
- R4: A test packet of 64 counter words, where lane i of word n holds (4n + i) mod 256 with flags clear, followed by an end character, raises the good-packet count by one.
- R5: Each counter word that differs from the expected bytes or has any flag set raises the word-error count by one. The packet is then counted bad at its end, and checking continues with the expected value advanced by 4.
- R6: An end character that arrives before the 0xFC word has been checked raises the bad-packet count by one.
- R7: A data word after the 0xFC word raises the bad-packet count by one and sends the checker back to hunting for a start. The following packet is then checked normally.
- R8: All three counters saturate at their all-ones value.
- R9: A high stat_clear zeroes all counters on the next edge and takes priority over an increment in the same cycle.
- R10: in_ready is always high. After reset all counters read zero.
- R11: An end character with one corrupted copy, such as one flag missing, still ends the packet.
- R12: A word presented with in_valid low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Always high |
| in_data | input | 32 | Four byte lanes, lane 0 in bits 7:0 |
| in_kflag | input | 4 | Control-character flag per lane |
| stat_clear | input | 1 | Synchronous clear of all counters |
| good_pkts | output | CNT_W (16) | Good test packets |
| bad_pkts | output | CNT_W (16) | Bad test packets |
| word_errs | output | CNT_W (16) | Mismatching counter words |

## Verification
Clean test packets are sent with idle words and invalid cycles placed inside them, including an invalid word that carries an end character. A missed filter or a missed valid gate shows up as a lost good count. Start and end characters with one flipped bit or one dropped flag separate a true majority vote from an all-lanes match. A foreign-type packet whose payload looks exactly like a counter leaves every counter unchanged, which shows the type decode and the skipping. A single corrupted word, a short packet, an over-long packet and a packet of all-wrong words run with narrow counters tell apart the per-word error count, the packet verdicts, the recovery of framing and saturation.

// File: rtl/ltc_pkg.sv
// Shared constants and types for the link test pattern checker.
package ltc_pkg;
    localparam int CHAR_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = CHAR_W * LANES;

    // Control code from its x.y notation.
    function automatic logic [CHAR_W-1:0] kcode(input int x, input int y);
        return CHAR_W'((y << 5) | x);
    endfunction

    localparam logic [CHAR_W-1:0] K_SOP   = kcode(27, 7);
    localparam logic [CHAR_W-1:0] K_EOP   = kcode(29, 7);
    localparam logic [CHAR_W-1:0] K_MARK  = kcode(28, 3);
    localparam logic [CHAR_W-1:0] K_COMMA = kcode(28, 5);
    localparam logic [CHAR_W-1:0] K_ALIGN = kcode(28, 1);
    localparam logic [CHAR_W-1:0] D_TAIL  = 8'hB5;
    localparam logic [WORD_W-1:0] IDLE_DATA = {D_TAIL, K_ALIGN, K_ALIGN, K_COMMA};
    localparam logic [LANES-1:0]  IDLE_K    = 4'b0111;
    localparam logic [CHAR_W-1:0] TYPE_TEST = 8'h04;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_TYPE  = 2'd1,
        ST_COUNT = 2'd2,
        ST_SKIP  = 2'd3
    } chk_state_t;
endpackage

// File: rtl/ltc_vote.sv
// Two-stage majority voter over four duplicated lanes.
// Stage 1 registers the AND of every 3-of-4 lane combination; stage 2
// ORs them. The raw word and its flags travel alongside so that the
// counter check sees the unvoted bytes. Assumes exactly four lanes.
module ltc_vote
    import ltc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    input  logic [WORD_W-1:0] a_data,
    input  logic [LANES-1:0]  a_k,
    output logic              v_valid,
    output logic [CHAR_W-1:0] v_char,
    output logic              v_k,
    output logic [WORD_W-1:0] v_data,
    output logic [LANES-1:0]  v_kraw
);
    logic [CHAR_W-1:0] tri_c [LANES];
    logic [LANES-1:0]  tri_k;
    logic [CHAR_W-1:0] s1_c  [LANES];
    logic [LANES-1:0]  s1_k;
    logic              s1_valid;
    logic [WORD_W-1:0] s1_data;
    logic [LANES-1:0]  s1_kraw;

    // Each combination leaves out one lane.
    for (genvar j = 0; j < LANES; j++) begin : g_tri
        always_comb begin
            tri_c[j] = '1;
            tri_k[j] = 1'b1;
            for (int i = 0; i < LANES; i++) begin
                if (i != j) begin
                    tri_c[j] = tri_c[j] & a_data[i*CHAR_W +: CHAR_W];
                    tri_k[j] = tri_k[j] & a_k[i];
                end
            end
        end
    end

    // Stage 1: register combination ANDs and the raw word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_k     <= '0;
            s1_data  <= '0;
            s1_kraw  <= '0;
            for (int j = 0; j < LANES; j++) s1_c[j] <= '0;
        end else begin
            s1_valid <= a_valid;
            s1_k     <= tri_k;
            s1_data  <= a_data;
            s1_kraw  <= a_k;
            for (int j = 0; j < LANES; j++) s1_c[j] <= tri_c[j];
        end
    end

    // Stage 2: OR the combinations into the voted character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_valid <= 1'b0;
            v_char  <= '0;
            v_k     <= 1'b0;
            v_data  <= '0;
            v_kraw  <= '0;
        end else begin
            logic [CHAR_W-1:0] c;
            c = '0;
            for (int j = 0; j < LANES; j++) c = c | s1_c[j];
            v_valid <= s1_valid;
            v_char  <= c;
            v_k     <= |s1_k;
            v_data  <= s1_data;
            v_kraw  <= s1_kraw;
        end
    end
endmodule

// File: rtl/ltc_seq_check.sv
// Packet framer and counter-pattern checker.
// Hunts for a voted start character, decodes the type word, then either
// checks counter words or skips to the voted end character. Emits one-cycle
// increment strobes for the good, bad and word-error counters.
module ltc_seq_check
    import ltc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_valid,
    input  logic [CHAR_W-1:0] v_char,
    input  logic              v_k,
    input  logic [WORD_W-1:0] v_data,
    input  logic [LANES-1:0]  v_kraw,
    output logic              inc_good,
    output logic              inc_bad,
    output logic              inc_werr
);
    localparam int EXP_W = CHAR_W + 1;
    localparam logic [EXP_W-1:0] EXP_END = EXP_W'(1 << CHAR_W);

    chk_state_t        state, state_nx;
    logic [EXP_W-1:0]  expv, expv_nx;
    logic              bad, bad_nx;
    logic [WORD_W-1:0] exp_word;
    logic              is_sop, is_eop, is_test;

    // Expected bytes: lane i holds the counter plus i.
    always_comb begin
        for (int i = 0; i < LANES; i++)
            exp_word[i*CHAR_W +: CHAR_W] = expv[CHAR_W-1:0] + CHAR_W'(i);
    end

    // Voted character classification.
    always_comb begin
        is_sop  = v_k && (v_char == K_SOP);
        is_eop  = v_k && (v_char == K_EOP);
        is_test = !v_k && (v_char == TYPE_TEST);
    end

    // Next-state and strobe logic.
    always_comb begin
        state_nx = state;
        expv_nx  = expv;
        bad_nx   = bad;
        inc_good = 1'b0;
        inc_bad  = 1'b0;
        inc_werr = 1'b0;
        if (v_valid) begin
            unique case (state)
                ST_HUNT: if (is_sop) state_nx = ST_TYPE;
                ST_TYPE: begin
                    if (is_eop)       state_nx = ST_HUNT;
                    else if (is_test) begin
                        state_nx = ST_COUNT;
                        expv_nx  = '0;
                        bad_nx   = 1'b0;
                    end else          state_nx = ST_SKIP;
                end
                ST_COUNT: begin
                    if (is_eop) begin
                        state_nx = ST_HUNT;
                        if (expv == EXP_END && !bad) inc_good = 1'b1;
                        else                         inc_bad  = 1'b1;
                    end else if (expv == EXP_END) begin
                        state_nx = ST_HUNT;
                        inc_bad  = 1'b1;
                    end else begin
                        if (v_data != exp_word || v_kraw != '0) begin
                            inc_werr = 1'b1;
                            bad_nx   = 1'b1;
                        end
                        expv_nx = expv + EXP_W'(LANES);
                    end
                end
                ST_SKIP: if (is_eop) state_nx = ST_HUNT;
                default: state_nx = ST_HUNT;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            expv  <= '0;
            bad   <= 1'b0;
        end else begin
            state <= state_nx;
            expv  <= expv_nx;
            bad   <= bad_nx;
        end
    end
endmodule

// File: rtl/ltc_sat_cnt.sv
// Saturating up-counter with synchronous clear; clear wins over increment.
module ltc_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    // Count, hold at all-ones, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                 q <= '0;
        else if (clr)               q <= '0;
        else if (inc && q != '1)    q <= q + W'(1);
    end
endmodule

// File: rtl/lane_test_checker.sv
// Top: filters idle words, votes on duplicated characters, checks
// connection-test packets and keeps three saturating counters.
// Assumes the input is already symbol-decoded and lane-aligned.
module lane_test_checker
    import ltc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic [LANES-1:0]  in_kflag,
    input  logic              stat_clear,
    output logic [CNT_W-1:0]  good_pkts,
    output logic [CNT_W-1:0]  bad_pkts,
    output logic [CNT_W-1:0]  word_errs
);
    localparam int NCNT = 3;

    logic              keep;
    logic              v_valid, v_k;
    logic [CHAR_W-1:0] v_char;
    logic [WORD_W-1:0] v_data;
    logic [LANES-1:0]  v_kraw;
    logic [NCNT-1:0]   inc;
    logic [CNT_W-1:0]  cnt [NCNT];

    assign in_ready = 1'b1;

    // Drop idle words before the voter.
    always_comb keep = in_valid && !(in_data == IDLE_DATA && in_kflag == IDLE_K);

    ltc_vote u_vote (
        .clk(clk), .rst_n(rst_n),
        .a_valid(keep), .a_data(in_data), .a_k(in_kflag),
        .v_valid(v_valid), .v_char(v_char), .v_k(v_k),
        .v_data(v_data), .v_kraw(v_kraw)
    );

    ltc_seq_check u_chk (
        .clk(clk), .rst_n(rst_n),
        .v_valid(v_valid), .v_char(v_char), .v_k(v_k),
        .v_data(v_data), .v_kraw(v_kraw),
        .inc_good(inc[0]), .inc_bad(inc[1]), .inc_werr(inc[2])
    );

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        ltc_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(stat_clear),
            .inc(inc[c]), .q(cnt[c])
        );
    end

    assign good_pkts = cnt[0];
    assign bad_pkts  = cnt[1];
    assign word_errs = cnt[2];
endmodule

// File: rtl/lane_test_checker_sva.sv
// Port-level properties of the link test pattern checker, bound to the top.
module lane_test_checker_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             stat_clear,
    input logic [CNT_W-1:0] good_pkts,
    input logic [CNT_W-1:0] bad_pkts,
    input logic [CNT_W-1:0] word_errs
);
    p_ready_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == 1'b1);

    p_clear_zeroes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clear |=> (good_pkts == '0 && bad_pkts == '0 && word_errs == '0));

    p_good_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clear |=> (good_pkts == $past(good_pkts) || good_pkts == $past(good_pkts) + 1'b1));

    p_bad_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clear |=> (bad_pkts == $past(bad_pkts) || bad_pkts == $past(bad_pkts) + 1'b1));

    p_werr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clear |=> (word_errs == $past(word_errs) || word_errs == $past(word_errs) + 1'b1));

    p_good_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_clear && good_pkts == '1) |=> good_pkts == '1);

    p_werr_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_clear && word_errs == '1) |=> word_errs == '1);

    p_one_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clear |=> !(good_pkts != $past(good_pkts) && bad_pkts != $past(bad_pkts)));
endmodule

bind lane_test_checker lane_test_checker_sva #(.CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .stat_clear(stat_clear),
    .good_pkts(good_pkts), .bad_pkts(bad_pkts), .word_errs(word_errs)
);

// File: tb/lane_test_checker_tb_top.sv
// Directed bench; counters narrowed to 4 bits to reach saturation quickly.
module lane_test_checker_tb_top;
    localparam int CW = 4;
    localparam logic [31:0] IDLE = 32'hB53C3CBC;
    localparam logic [31:0] SOP  = {4{8'hFB}};
    localparam logic [31:0] EOP  = {4{8'hFD}};

    logic clk = 0, rst_n = 0, in_valid = 0, stat_clear = 0;
    logic in_ready;
    logic [31:0] in_data = '0;
    logic [3:0]  in_kflag = '0;
    logic [CW-1:0] good_pkts, bad_pkts, word_errs;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    lane_test_checker #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_kflag(in_kflag), .stat_clear(stat_clear),
        .good_pkts(good_pkts), .bad_pkts(bad_pkts), .word_errs(word_errs)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic put(input logic v, input logic [31:0] d, input logic [3:0] k);
        @(negedge clk);
        in_valid = v; in_data = d; in_kflag = k;
    endtask

    function automatic logic [31:0] cword(input int n);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) w[i*8 +: 8] = 8'((4*n + i) & 8'hFF);
        return w;
    endfunction

    // mode: 0 clean, 1 interleave idles/invalid words and fuzz SOP/EOP
    task automatic send_test(input int nwords, input int bad_idx, input int mode);
        put(1, (mode == 1) ? (SOP ^ 32'h0000_1000) : SOP, 4'hF);
        put(1, 32'h04040404, 4'h0);
        for (int n = 0; n < nwords; n++) begin
            logic [31:0] w;
            w = cword(n);
            if (bad_idx == n) w[23:16] = w[23:16] ^ 8'h40;
            if (bad_idx == -2) w = '0;
            put(1, w, 4'h0);
            if (mode == 1 && n % 9 == 3) put(1, IDLE, 4'b0111);
            if (mode == 1 && n % 13 == 5) put(0, EOP, 4'hF);
        end
        put(1, EOP, (mode == 1) ? 4'b1011 : 4'hF);
    endtask

    task automatic flush();
        for (int i = 0; i < 4; i++) put(1, IDLE, 4'b0111);
        put(0, '0, '0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 ready", in_ready, 1);
        chk("R10 good reset", good_pkts, 0);
        chk("R10 bad reset", bad_pkts, 0);
        chk("R10 werr reset", word_errs, 0);
    endtask

    task automatic t_clean();
        send_test(64, -1, 0); flush();
        chk("R4 clean good", good_pkts, 1);
        chk("R4 clean no werr", word_errs, 0);
    endtask

    task automatic t_fuzz();
        send_test(64, -1, 1); flush();
        chk("R1 R2 R11 R12 fuzzed good", good_pkts, 2);
        chk("R12 no bad", bad_pkts, 0);
    endtask

    task automatic t_foreign();
        put(1, SOP, 4'hF);
        put(1, 32'h05050505, 4'h0);
        for (int n = 0; n < 70; n++) put(1, cword(n), 4'h0);
        put(1, EOP, 4'hF); flush();
        chk("R3 foreign good", good_pkts, 2);
        chk("R3 foreign bad", bad_pkts, 0);
        chk("R3 foreign werr", word_errs, 0);
        send_test(64, -1, 0); flush();
        chk("R3 after foreign", good_pkts, 3);
    endtask

    task automatic t_one_err();
        send_test(64, 10, 0); flush();
        chk("R5 werr one", word_errs, 1);
        chk("R5 bad", bad_pkts, 1);
        chk("R5 good unchanged", good_pkts, 3);
    endtask

    task automatic t_short();
        send_test(20, -1, 0); flush();
        chk("R6 short bad", bad_pkts, 2);
        chk("R6 short werr", word_errs, 1);
    endtask

    task automatic t_long();
        send_test(65, -1, 0); flush();
        chk("R7 long bad", bad_pkts, 3);
        send_test(64, -1, 0); flush();
        chk("R7 recover good", good_pkts, 4);
        chk("R7 bad held", bad_pkts, 3);
    endtask

    task automatic t_clear();
        @(negedge clk) stat_clear = 1;
        @(negedge clk) stat_clear = 0;
        chk("R9 good clr", good_pkts, 0);
        chk("R9 bad clr", bad_pkts, 0);
        chk("R9 werr clr", word_errs, 0);
    endtask

    task automatic t_sat();
        send_test(64, -2, 0); flush();
        chk("R8 werr sat", word_errs, 15);
        chk("R8 bad one", bad_pkts, 1);
        for (int p = 0; p < 17; p++) send_test(64, -1, 0);
        flush();
        chk("R8 good sat", good_pkts, 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_clean(); t_fuzz(); t_foreign(); t_one_err();
        t_short(); t_long(); t_clear(); t_sat();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule